// File: doc/BRIEF.md
# Pipelined Column-Sum Unsigned Multiplier

This block multiplies two 4-bit unsigned operands into an 8-bit product. It does not add shifted rows of partial products. Instead it works through the product one output column at a time. For each column it counts the single-bit partial products whose bit indices add up to that column, then adds the carry left over from the column below. The lowest bit of that total is the product bit, and the remaining bits move up as carry into the next column.

The column chain is split across four register ranks. This gives a short critical path, and the block accepts a fresh operand pair on every clock cycle. A valid flag travels with each pair. Each stage register carries forward the operands, the product bits resolved so far and the pending carry, so later stages can form their own partial products. The block has no stall or backpressure: a result leaves the pipeline exactly four cycles after its operands were taken in.

Top module: `mulcol_mult`

## Requirements
- R1: For every pair of 4-bit unsigned operands, `out_product` equals the arithmetic product `in_a * in_b` as an 8-bit unsigned value.
- R2: Product bit 0 equals `in_a[0] & in_b[0]`, and column 0 passes no carry upward.
- R3: For each column k from 1 to 6, the column total is the number of set products `in_a[i] & in_b[j]` with i + j = k, plus the carry from column k-1. Bit 0 of that total is product bit k. The product bits already resolved in earlier stages pass through later stages unchanged.
- R4: A 3-bit total is enough for every column, so no column overflows. Product bit 7 is the low carry bit left above column 6, and the high carry bit there is always zero.
- R5: A synchronous active-high `rst` clears every in-flight valid flag. `out_valid` is low during reset and for the first four cycles after release, unless new valid input enters after release.
- R6: A pair sampled with `in_valid` high at a rising edge appears on `out_product` with `out_valid` high after the fourth rising edge, counting that edge as the first.
- R7: A new operand pair can be accepted on every cycle. Back-to-back inputs produce back-to-back results, in order, on consecutive cycles.
- R8: A cycle with `in_valid` low makes `out_valid` low exactly four cycles later. Gaps in the input stream reappear unchanged in the output stream.
- R9: Each stage register forwards the operands and the valid flag of its pair unchanged to the next stage, so each result is formed only from its own operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, clears the valid flags |
| in_valid | input | 1 | Marks `in_a`/`in_b` as a pair to multiply this cycle |
| in_a | input | 4 | Unsigned multiplicand |
| in_b | input | 4 | Unsigned multiplier |
| out_valid | output | 1 | High when `out_product` holds a result |
| out_product | output | 8 | Unsigned product, four cycles after input |

## Verification
Some checks run on every cycle, next to the logic they guard. These cover the valid flag and operands advancing one stage per edge, resolved product bits holding their value, no column total overflowing its three bits, and zero high carry above the top column. They also compare each output against a reference multiply of the inputs from four cycles earlier.

Other behaviours can only be shown by the bench's scenarios, which drive the block through its ports. These are the full 256-pair sweep pushed back to back, bubble patterns reappearing with the right spacing, and a reset in the middle of a stream that removes every in-flight result. Together they show that ordering, throughput and flushing behave as required.

// File: rtl/mulcol_pkg.sv
package mulcol_pkg;

    parameter int unsigned OP_W       = 4;
    parameter int unsigned NUM_STAGES = 4;

    localparam int unsigned PROD_W   = 2 * OP_W;
    localparam int unsigned NUM_COLS = 2 * OP_W - 1;
    // A column total never exceeds 2*OP_W-1, so this width cannot overflow.
    localparam int unsigned SUM_W    = $clog2(2 * OP_W);
    localparam int unsigned CARRY_W  = SUM_W - 1;

    typedef logic [OP_W-1:0]    operand_t;
    typedef logic [PROD_W-1:0]  product_t;
    typedef logic [CARRY_W-1:0] carry_t;

    // One pipeline lane: everything later stages need about one pair.
    typedef struct packed {
        logic     valid;
        operand_t a;
        operand_t b;
        product_t prod;
        carry_t   carry;
    } lane_t;

    // Stage that resolves a given column; columns spread evenly over stages.
    function automatic int unsigned col_owner(int unsigned k);
        return (k * NUM_STAGES) / NUM_COLS;
    endfunction

    function automatic int unsigned first_col(int unsigned s);
        int unsigned r;
        r = NUM_COLS;
        for (int k = int'(NUM_COLS) - 1; k >= 0; k--) begin
            if (col_owner(k) == s) r = k;
        end
        return r;
    endfunction

    function automatic int unsigned last_col(int unsigned s);
        int unsigned r;
        r = 0;
        for (int k = 0; k < int'(NUM_COLS); k++) begin
            if (col_owner(k) == s) r = k;
        end
        return r;
    endfunction

endpackage

// File: rtl/mulcol_column.sv
module mulcol_column
    import mulcol_pkg::*;
#(
    parameter int unsigned COL = 0
) (
    input  operand_t a,
    input  operand_t b,
    input  carry_t   carry_in,
    output logic     bit_o,
    output carry_t   carry_o,
    output logic     ovf_o
);

    localparam int unsigned ACC_W = SUM_W + 1;

    logic [OP_W-1:0] pp;
    logic [ACC_W-1:0] acc;

    // Gather the crosswise partial products whose indices sum to COL.
    for (genvar i = 0; i < int'(OP_W); i++) begin : g_pp
        if ((int'(COL) >= i) && (int'(COL) - i < int'(OP_W))) begin : g_on
            assign pp[i] = a[i] & b[int'(COL) - i];
        end else begin : g_off
            assign pp[i] = 1'b0;
        end
    end

    always_comb begin
        acc = ACC_W'(carry_in) + ACC_W'($countones(pp));
    end

    assign bit_o   = acc[0];
    assign carry_o = acc[SUM_W-1:1];
    assign ovf_o   = acc[SUM_W];

endmodule

// File: rtl/mulcol_stage.sv
module mulcol_stage
    import mulcol_pkg::*;
#(
    parameter int unsigned STAGE = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  lane_t lane_i,
    output lane_t lane_o
);

    localparam int unsigned FIRST   = first_col(STAGE);
    localparam int unsigned LAST    = last_col(STAGE);
    localparam bit          IS_LAST = (STAGE == NUM_STAGES - 1);

    carry_t           chain [FIRST:LAST+1];
    logic [LAST:FIRST] col_bits;
    logic [LAST:FIRST] col_ovf;
    lane_t            nxt;
    logic             warm;

    assign chain[FIRST] = lane_i.carry;

    for (genvar k = int'(FIRST); k <= int'(LAST); k++) begin : g_col
        mulcol_column #(.COL(k)) u_col (
            .a        (lane_i.a),
            .b        (lane_i.b),
            .carry_in (chain[k]),
            .bit_o    (col_bits[k]),
            .carry_o  (chain[k+1]),
            .ovf_o    (col_ovf[k])
        );
    end

    always_comb begin
        nxt = lane_i;
        nxt.prod[LAST:FIRST] = col_bits;
        nxt.carry = chain[LAST+1];
        if (IS_LAST) begin
            nxt.prod[PROD_W-1] = chain[LAST+1][0];
            nxt.carry          = '0;
        end
    end

    always_ff @(posedge clk) begin
        lane_o <= nxt;
        if (rst) lane_o.valid <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) warm <= 1'b0;
        else     warm <= 1'b1;
    end

    // R5: reset leaves no valid flag behind
    p_reset_clears_r5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lane_o.valid);

    // R6 / R8: valid advances exactly one rank per edge
    p_valid_advance_r6: assert property (@(posedge clk) disable iff (rst)
        warm |-> (lane_o.valid == $past(lane_i.valid)));

    // R9: operands travel unchanged with their pair
    p_operands_carried_r9: assert property (@(posedge clk) disable iff (rst)
        (warm && lane_o.valid) |->
            (lane_o.a == $past(lane_i.a)) && (lane_o.b == $past(lane_i.b)));

    // R4: no column total spills past its width
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        lane_i.valid |-> (col_ovf == '0));

    if (FIRST > 0) begin : g_keep
        // R3: bits resolved upstream are not disturbed here
        p_low_bits_kept_r3: assert property (@(posedge clk) disable iff (rst)
            (warm && lane_o.valid) |->
                (lane_o.prod[FIRST-1:0] == $past(lane_i.prod[FIRST-1:0])));
    end

    if (IS_LAST && (CARRY_W > 1)) begin : g_top
        // R4: only the low carry bit may be set above the top column
        p_top_carry_clear_r4: assert property (@(posedge clk) disable iff (rst)
            lane_i.valid |-> (chain[LAST+1][CARRY_W-1:1] == '0));
    end

endmodule

// File: rtl/mulcol_mult.sv
module mulcol_mult
    import mulcol_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_a,
    input  logic [OP_W-1:0]   in_b,
    output logic              out_valid,
    output logic [PROD_W-1:0] out_product
);

    localparam int unsigned CNT_W = $clog2(NUM_STAGES + 1);
    localparam logic [CNT_W-1:0] SETTLE_MAX = CNT_W'(NUM_STAGES);

    lane_t lanes [0:NUM_STAGES];

    always_comb begin
        lanes[0]       = '0;
        lanes[0].valid = in_valid;
        lanes[0].a     = in_a;
        lanes[0].b     = in_b;
    end

    for (genvar s = 0; s < int'(NUM_STAGES); s++) begin : g_stage
        mulcol_stage #(.STAGE(s)) u_stage (
            .clk    (clk),
            .rst    (rst),
            .lane_i (lanes[s]),
            .lane_o (lanes[s+1])
        );
    end

    assign out_valid   = lanes[NUM_STAGES].valid;
    assign out_product = lanes[NUM_STAGES].prod;

    // Cycles since reset release, saturating at the pipeline depth.
    logic [CNT_W-1:0] settle;
    always_ff @(posedge clk) begin
        if (rst)                      settle <= '0;
        else if (settle != SETTLE_MAX) settle <= settle + 1'b1;
    end

    // R1: output matches a reference multiply of the inputs from NUM_STAGES cycles back
    p_product_match_r1: assert property (@(posedge clk) disable iff (rst)
        ((settle == SETTLE_MAX) && out_valid) |->
            (out_product == (PROD_W'($past(in_a, NUM_STAGES)) * PROD_W'($past(in_b, NUM_STAGES)))));

    // R2: lowest product bit is the AND of the operand LSBs
    p_bit0_r2: assert property (@(posedge clk) disable iff (rst)
        ((settle == SETTLE_MAX) && out_valid) |->
            (out_product[0] == ($past(in_a[0], NUM_STAGES) & $past(in_b[0], NUM_STAGES))));

    // R6: output valid is the input valid delayed by the pipeline depth
    p_valid_latency_r6: assert property (@(posedge clk) disable iff (rst)
        (settle == SETTLE_MAX) |-> (out_valid == $past(in_valid, NUM_STAGES)));

    // R9: the result belongs to the operands that travelled with it; no carry remains
    p_lane_consistent_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_product == (PROD_W'(lanes[NUM_STAGES].a) * PROD_W'(lanes[NUM_STAGES].b)))
                       && (lanes[NUM_STAGES].carry == '0)));

endmodule

// File: tb/mulcol_mult_bench.sv
`timescale 1ns/1ps
module mulcol_mult_bench;
    import mulcol_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [OP_W-1:0]   in_a = '0;
    logic [OP_W-1:0]   in_b = '0;
    logic              out_valid;
    logic [PROD_W-1:0] out_product;

    int    checks = 0;
    int    errors = 0;
    string req = "R5";
    bit    done = 1'b0;

    // Expected output history: index 3 is what leaves the pipe this cycle.
    logic              hv   [4];
    logic [PROD_W-1:0] hexp [4];

    always #2.5 clk = ~clk;

    mulcol_mult u_mulcol_mult (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_a        (in_a),
        .in_b        (in_b),
        .out_valid   (out_valid),
        .out_product (out_product)
    );

    task automatic clear_hist();
        for (int i = 0; i < 4; i++) begin
            hv[i]   = 1'b0;
            hexp[i] = '0;
        end
    endtask

    task automatic check_out();
        checks++;
        if (out_valid !== hv[3]) begin
            errors++;
            $display("FAIL %s: out_valid got %b expected %b", req, out_valid, hv[3]);
        end
        if (hv[3]) begin
            checks++;
            if (out_product !== hexp[3]) begin
                errors++;
                $display("FAIL %s: out_product got %0d expected %0d", req, out_product, hexp[3]);
            end
        end
    endtask

    // One cycle: check what leaves, then drive the next input.
    task automatic step(input logic v, input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
        @(negedge clk);
        check_out();
        for (int i = 3; i > 0; i--) begin
            hv[i]   = hv[i-1];
            hexp[i] = hexp[i-1];
        end
        hv[0]   = v;
        hexp[0] = PROD_W'(a) * PROD_W'(b);
        in_valid = v;
        in_a     = a;
        in_b     = b;
    endtask

    task automatic drain();
        for (int i = 0; i < 5; i++) step(1'b0, '0, '0);
    endtask

    // R5: outputs are idle in and after reset
    task automatic t_reset_state();
        req = "R5";
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        clear_hist();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
                errors++;
                $display("FAIL R5: out_valid in reset got %b expected 0", out_valid);
            end
        end
        rst = 1'b0;
        for (int i = 0; i < 5; i++) step(1'b0, '0, '0);
    endtask

    // R6: a lone pair emerges after exactly four edges; R2 bit 0
    task automatic t_latency();
        req = "R6 R2";
        step(1'b1, 4'd9, 4'd7);
        for (int i = 0; i < 3; i++) step(1'b0, 4'd3, 4'd3);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b1 || out_product !== 8'd63 || out_product[0] !== 1'b1) begin
            errors++;
            $display("FAIL R6: latency result got v=%b p=%0d expected v=1 p=63", out_valid, out_product);
        end
        // re-align history: that sample consumed one output slot
        for (int i = 3; i > 0; i--) begin
            hv[i] = hv[i-1]; hexp[i] = hexp[i-1];
        end
        hv[0] = 1'b0; hexp[0] = '0; in_valid = 1'b0;
        drain();
    endtask

    // R1 R7 R9: all pairs pushed back to back
    task automatic t_sweep();
        req = "R1 R7 R9";
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                step(1'b1, 4'(a), 4'(b));
            end
        end
        drain();
    endtask

    // R2 R3 R4: carry-heavy and edge operands
    task automatic t_corners();
        req = "R2 R3 R4";
        step(1'b1, 4'd15, 4'd15);
        step(1'b1, 4'd15, 4'd1);
        step(1'b1, 4'd8,  4'd8);
        step(1'b1, 4'd0,  4'd15);
        step(1'b1, 4'd1,  4'd1);
        step(1'b1, 4'd14, 4'd13);
        step(1'b1, 4'd5,  4'd3);
        step(1'b1, 4'd12, 4'd15);
        drain();
    endtask

    // R8: gaps in the input reappear four cycles later
    task automatic t_bubbles();
        req = "R8";
        step(1'b1, 4'd6, 4'd11);
        step(1'b0, 4'd15, 4'd15);
        step(1'b1, 4'd13, 4'd2);
        step(1'b1, 4'd7, 4'd9);
        step(1'b0, 4'd1, 4'd1);
        step(1'b0, 4'd2, 4'd2);
        step(1'b1, 4'd11, 4'd14);
        step(1'b0, 4'd15, 4'd15);
        step(1'b1, 4'd3, 4'd10);
        drain();
    endtask

    // R5: reset in mid-stream flushes every in-flight result
    task automatic t_reset_flush();
        req = "R5";
        step(1'b1, 4'd9, 4'd9);
        step(1'b1, 4'd10, 4'd11);
        step(1'b1, 4'd12, 4'd13);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        clear_hist();
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R5: out_valid after flush got %b expected 0", out_valid);
        end
        rst = 1'b0;
        for (int i = 0; i < 6; i++) step(1'b0, 4'd15, 4'd15);
        step(1'b1, 4'd4, 4'd5);
        drain();
    endtask

    initial begin
        clear_hist();
        t_reset_state();
        t_latency();
        t_sweep();
        t_corners();
        t_bubbles();
        t_reset_flush();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL %s: watchdog got hang expected finish", req);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule